// File: doc/BRIEF.md
# Ultra DMA Operation Control and Status Unit

This unit sits beside the Ultra DMA data engine of a parallel ATA host. Software reaches it through a small register bus. It holds a transfer configuration byte and an operation register that carries the transfer direction and the engine enable. It also holds a register that drives the four active-low bus control lines to the drive, which are the two chip selects, the read strobe and the write strobe.

The enable cannot be set by a single write. Software first writes the direction with the enable clear. It then reads the operation register once. Only after that does a write with the enable set take effect, and that write must carry the same direction. An out-of-order enable write is dropped and a sequence-error flag is raised. Writing an all-zero word to the operation register stops the transfer. It clears the sticky flags and returns every bus control line to its idle high level.

Error pulses from the data engine are held until that zero write. Together with the live request and busy levels, they form a status word. The unit also reduces the status to one two-bit class, so that an interrupt handler can decide what to do with a single read.

Top module: `udma_ctl`

## Requirements
- R1: Address 0 holds an 8-bit configuration value. A write stores reg_wdata[7:0]. A read returns it in bits 7:0, and all other bits read zero.
- R2: A read of address 1 returns the direction in bit 1 and the enable in bit 0. A read of address 3 returns the bus control lines in bits 3:0, ordered cs0_n, cs1_n, dior_n, diow_n from bit 0 up. A write to address 3 sets those lines from reg_wdata[3:0]. reg_rdata is zero in any cycle without reg_rd.
- R3: A write to address 1 with bit 0 clear disables the transfer and stores bit 1 as the direction. If a read of address 1 follows it, a later write with bit 0 set and the same bit 1 drives udma_en high from the next cycle.
- R4: A write to address 1 with bit 0 set is ignored in two cases: when no read-back has happened since the last direction write, or when its bit 1 differs from the stored direction. In either case seq_err goes high and stays high until the next all-zero write to address 1.
- R5: An all-zero write to address 1 clears udma_en and udma_dir in the next cycle and drives all four bus control lines high.
- R6: A read of address 2 returns the status word, with seq_err in bit 0, eng_req in bit 16, the held error interrupt in bit 17, eng_busy in bit 18, the held data-out-incomplete flag in bit 24, the held data-in-incomplete flag in bit 25 and the held bad-length flag in bit 26. The four held flags set one cycle after their input pulse. They clear only on an all-zero write to address 1, and a pulse that arrives in the same cycle as that write is still held.
- R7: The output xfer_cls follows a fixed priority. It is 3 (error) if any held flag is set. Otherwise it is 2 (interrupt) if ata_intrq is high. Otherwise it is 1 (active) if eng_busy or eng_req is high. Otherwise it is 0 (idle).
- R8: After reset the configuration is 0, the enable, direction and seq_err are 0, no flag is held, and all four bus control lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (2) | Register address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, valid in the cycle of reg_rd |
| ata_intrq | input | 1 | Drive interrupt request pin level |
| eng_req | input | 1 | Data engine DMA request level |
| eng_busy | input | 1 | Data engine not idle |
| eng_err_irq | input | 1 | Data engine error interrupt pulse |
| eng_out_short | input | 1 | Data-out incomplete pulse |
| eng_in_short | input | 1 | Data-in incomplete pulse |
| eng_len_bad | input | 1 | Length not a multiple of four words, pulse |
| udma_en | output | 1 | Transfer enable to the data engine |
| udma_dir | output | 1 | Direction, 1 = write to device |
| seq_err | output | 1 | Enable was written out of sequence |
| xfer_cls | output | 2 | Status class: 0 idle, 1 active, 2 interrupt, 3 error |
| cs0_n | output | 1 | Chip select 0, active low |
| cs1_n | output | 1 | Chip select 1, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |

## Verification
Two events can land in the same clock: a stop write, which clears the held flags, and a new error pulse from the engine. The bench forces this case on purpose by raising an error input in the very cycle of the all-zero write. It then checks that the flag is still held and that the class stays at error. Throughout a long random phase, the bench keeps a behavioural model of the held flags and the arming state. It compares that model with every output and read value on every clock, so both collisions and the read-back/enable ordering are judged cycle by cycle.

// File: rtl/udma_ctl_pkg.sv
package udma_ctl_pkg;

    typedef enum logic [1:0] {
        CLS_IDLE   = 2'd0,
        CLS_ACTIVE = 2'd1,
        CLS_INTR   = 2'd2,
        CLS_ERROR  = 2'd3
    } udma_cls_e;

    typedef struct packed {
        logic eirq;
        logic out_short;
        logic in_short;
        logic len_bad;
    } udma_err_t;

    // register addresses
    localparam int A_CFG   = 0;
    localparam int A_OP    = 1;
    localparam int A_STAT  = 2;
    localparam int A_LINES = 3;

    // status word bit positions (decoded by software)
    localparam int SB_SEQ  = 0;
    localparam int SB_REQ  = 16;
    localparam int SB_EIRQ = 17;
    localparam int SB_BUSY = 18;
    localparam int SB_OUT  = 24;
    localparam int SB_IN   = 25;
    localparam int SB_LEN  = 26;

endpackage

// File: rtl/udma_arm_seq.sv
module udma_arm_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_op,
    input  logic rd_op,
    input  logic wdata_en,
    input  logic wdata_dir,
    input  logic clr_all,
    output logic en,
    output logic dir,
    output logic seq_err
);

    typedef struct packed {
        logic en;
        logic dir;
        logic pend;
        logic rb;
        logic seq_err;
    } arm_t;

    arm_t arm_d, arm_q;

    always_comb begin
        arm_d = arm_q;
        if (wr_op) begin
            if (!wdata_en) begin
                arm_d.en   = 1'b0;
                arm_d.dir  = wdata_dir;
                arm_d.pend = 1'b1;
                arm_d.rb   = 1'b0;
                if (clr_all) arm_d.seq_err = 1'b0;
            end else begin
                if (arm_q.rb && (wdata_dir == arm_q.dir)) arm_d.en = 1'b1;
                else                                       arm_d.seq_err = 1'b1;
                arm_d.pend = 1'b0;
                arm_d.rb   = 1'b0;
            end
        end else if (rd_op && arm_q.pend) begin
            arm_d.pend = 1'b0;
            arm_d.rb   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= '0;
        else        arm_q <= arm_d;
    end

    assign en      = arm_q.en;
    assign dir     = arm_q.dir;
    assign seq_err = arm_q.seq_err;

    // R3
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm_q.en) |-> $past(arm_q.rb));

    // R4
    seq_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op && wdata_en && !arm_q.rb) |=> (arm_q.seq_err && $stable(arm_q.en)));

endmodule

// File: rtl/udma_err_gather.sv
module udma_err_gather
    import udma_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  udma_err_t err_in,
    output udma_err_t err_held
);

    udma_err_t err_d, err_q;

    always_comb begin
        if (clr) err_d = err_in;
        else     err_d = err_q | err_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign err_held = err_q;

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_q != '0) && !clr) |=> ((err_q & $past(err_q)) == $past(err_q)));

endmodule

// File: rtl/udma_classify.sv
module udma_classify
    import udma_ctl_pkg::*;
(
    input  udma_err_t err_held,
    input  logic      intrq,
    input  logic      busy,
    input  logic      req,
    output udma_cls_e cls
);

    always_comb begin
        if (err_held != '0)    cls = CLS_ERROR;
        else if (intrq)        cls = CLS_INTR;
        else if (busy || req)  cls = CLS_ACTIVE;
        else                   cls = CLS_IDLE;
    end

endmodule

// File: rtl/udma_ctl.sv
module udma_ctl
    import udma_ctl_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32,
    parameter int CFG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ata_intrq,
    input  logic              eng_req,
    input  logic              eng_busy,
    input  logic              eng_err_irq,
    input  logic              eng_out_short,
    input  logic              eng_in_short,
    input  logic              eng_len_bad,
    output logic              udma_en,
    output logic              udma_dir,
    output logic              seq_err,
    output logic [1:0]        xfer_cls,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic              dior_n,
    output logic              diow_n
);

    localparam int LINE_W = 4;

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic [LINE_W-1:0] lines;
    } top_t;

    top_t top_d, top_q;

    logic      wr_op, rd_op, clr_all;
    udma_err_t err_now, err_held;
    udma_cls_e cls;

    assign wr_op   = reg_wr && (reg_addr == ADDR_W'(A_OP));
    assign rd_op   = reg_rd && !reg_wr && (reg_addr == ADDR_W'(A_OP));
    assign clr_all = wr_op && (reg_wdata == '0);

    assign err_now = '{eirq: eng_err_irq, out_short: eng_out_short,
                       in_short: eng_in_short, len_bad: eng_len_bad};

    udma_arm_seq u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_op     (wr_op),
        .rd_op     (rd_op),
        .wdata_en  (reg_wdata[0]),
        .wdata_dir (reg_wdata[1]),
        .clr_all   (clr_all),
        .en        (udma_en),
        .dir       (udma_dir),
        .seq_err   (seq_err)
    );

    udma_err_gather u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_all),
        .err_in   (err_now),
        .err_held (err_held)
    );

    udma_classify u_cls (
        .err_held (err_held),
        .intrq    (ata_intrq),
        .busy     (eng_busy),
        .req      (eng_req),
        .cls      (cls)
    );

    always_comb begin
        top_d = top_q;
        if (reg_wr && (reg_addr == ADDR_W'(A_CFG)))   top_d.cfg   = reg_wdata[CFG_W-1:0];
        if (reg_wr && (reg_addr == ADDR_W'(A_LINES))) top_d.lines = reg_wdata[LINE_W-1:0];
        if (clr_all)                                  top_d.lines = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q.cfg   <= '0;
            top_q.lines <= '1;
        end else begin
            top_q <= top_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (int'(reg_addr))
                A_CFG:   reg_rdata[CFG_W-1:0] = top_q.cfg;
                A_OP:    reg_rdata[1:0]       = {udma_dir, udma_en};
                A_STAT: begin
                    reg_rdata[SB_SEQ]  = seq_err;
                    reg_rdata[SB_REQ]  = eng_req;
                    reg_rdata[SB_EIRQ] = err_held.eirq;
                    reg_rdata[SB_BUSY] = eng_busy;
                    reg_rdata[SB_OUT]  = err_held.out_short;
                    reg_rdata[SB_IN]   = err_held.in_short;
                    reg_rdata[SB_LEN]  = err_held.len_bad;
                end
                A_LINES: reg_rdata[LINE_W-1:0] = top_q.lines;
                default: reg_rdata = '0;
            endcase
        end
    end

    assign xfer_cls = cls;
    assign cs0_n    = top_q.lines[0];
    assign cs1_n    = top_q.lines[1];
    assign dior_n   = top_q.lines[2];
    assign diow_n   = top_q.lines[3];

    // R5
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (!udma_en && !udma_dir && cs0_n && cs1_n && dior_n && diow_n));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_cls == 2'd0) |-> (!ata_intrq && !eng_busy && !eng_req));

    // R7
    intr_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ata_intrq && (err_held == '0)) |-> (xfer_cls == 2'd2));

endmodule

// File: tb/udma_ctl_tb.sv
module udma_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ata_intrq = 1'b0, eng_req = 1'b0, eng_busy = 1'b0;
    logic        eng_err_irq = 1'b0, eng_out_short = 1'b0, eng_in_short = 1'b0, eng_len_bad = 1'b0;
    logic        udma_en, udma_dir, seq_err;
    logic [1:0]  xfer_cls;
    logic        cs0_n, cs1_n, dior_n, diow_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural model state
    bit       m_en, m_dir, m_wait_rb, m_rb_ok, m_seq;
    bit [3:0] m_err;   // {eirq, out, in, len}
    bit [7:0] m_cfg;
    bit [3:0] m_lines;

    always #5 clk = ~clk;

    udma_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ata_intrq(ata_intrq), .eng_req(eng_req), .eng_busy(eng_busy),
        .eng_err_irq(eng_err_irq), .eng_out_short(eng_out_short),
        .eng_in_short(eng_in_short), .eng_len_bad(eng_len_bad),
        .udma_en(udma_en), .udma_dir(udma_dir), .seq_err(seq_err),
        .xfer_cls(xfer_cls), .cs0_n(cs0_n), .cs1_n(cs1_n),
        .dior_n(dior_n), .diow_n(diow_n)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_dir = 0; m_wait_rb = 0; m_rb_ok = 0; m_seq = 0;
            m_err = 0; m_cfg = 0; m_lines = 4'hF;
        end else begin
            bit [3:0] pulses;
            bit stop;
            pulses = {eng_err_irq, eng_out_short, eng_in_short, eng_len_bad};
            stop = reg_wr && reg_addr == 2'd1 && reg_wdata == 32'd0;
            m_err = stop ? pulses : (m_err | pulses);
            if (reg_wr) begin
                if (reg_addr == 2'd0) m_cfg = reg_wdata[7:0];
                if (reg_addr == 2'd3) m_lines = reg_wdata[3:0];
                if (reg_addr == 2'd1) begin
                    if (reg_wdata[0] == 1'b0) begin
                        m_en = 0; m_dir = reg_wdata[1];
                        m_wait_rb = 1; m_rb_ok = 0;
                        if (stop) begin m_seq = 0; m_lines = 4'hF; end
                    end else begin
                        if (m_rb_ok && reg_wdata[1] == m_dir) m_en = 1;
                        else m_seq = 1;
                        m_wait_rb = 0; m_rb_ok = 0;
                    end
                end
            end else if (reg_rd && reg_addr == 2'd1 && m_wait_rb) begin
                m_wait_rb = 0; m_rb_ok = 1;
            end
        end
    end

    function automatic bit [1:0] exp_cls();
        if (m_err != 0) return 2'd3;
        if (ata_intrq) return 2'd2;
        if (eng_busy || eng_req) return 2'd1;
        return 2'd0;
    endfunction

    function automatic bit [31:0] exp_rdata();
        bit [31:0] v;
        v = 0;
        if (reg_rd) begin
            case (reg_addr)
                2'd0: v[7:0] = m_cfg;
                2'd1: v[1:0] = {m_dir, m_en};
                2'd2: begin
                    v[0] = m_seq; v[16] = eng_req; v[17] = m_err[3]; v[18] = eng_busy;
                    v[24] = m_err[2]; v[25] = m_err[1]; v[26] = m_err[0];
                end
                default: v[3:0] = m_lines;
            endcase
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 udma_en", 32'(udma_en), 32'(m_en));
            chk("R3 udma_dir", 32'(udma_dir), 32'(m_dir));
            chk("R4 seq_err", 32'(seq_err), 32'(m_seq));
            chk("R5 lines", 32'({diow_n, dior_n, cs1_n, cs0_n}), 32'(m_lines));
            chk("R7 xfer_cls", 32'(xfer_cls), 32'(exp_cls()));
            if (!reg_rd)              chk("R2 rdata idle", reg_rdata, exp_rdata());
            else if (reg_addr == 2'd0) chk("R1 rdata cfg", reg_rdata, exp_rdata());
            else if (reg_addr == 2'd2) chk("R6 rdata status", reg_rdata, exp_rdata());
            else                       chk("R2 rdata op/lines", reg_rdata, exp_rdata());
        end
    end

    task automatic bus(input logic w, input logic r, input logic [1:0] a, input logic [31:0] d);
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bus(0, 0, 0, 0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8 reset state, directed
        chk("R8 reset en", 32'(udma_en), 0);
        chk("R8 reset seq", 32'(seq_err), 0);
        chk("R8 reset lines", 32'({diow_n, dior_n, cs1_n, cs0_n}), 32'hF);
        chk("R8 reset cls", 32'(xfer_cls), 0);
        bus(0, 1, 0, 0);
        chk("R8 reset cfg", reg_rdata, 0);
        bus(0, 1, 2, 0);
        chk("R8 reset status", reg_rdata, 0);

        // R1 configuration store, upper bits dropped
        bus(1, 0, 0, 32'hABCD_1239);
        bus(0, 1, 0, 0);
        chk("R1 cfg readback", reg_rdata, 32'h39);

        // R2 bus lines
        bus(1, 0, 3, 32'h0000_0005);
        bus(0, 1, 3, 0);
        chk("R2 lines readback", reg_rdata, 32'h5);

        // R3 proper arming, direction write
        bus(1, 0, 1, 32'h2);
        bus(0, 1, 1, 0);
        bus(1, 0, 1, 32'h3);
        chk("R3 armed en", 32'(udma_en), 1);
        bus(0, 1, 1, 0);
        chk("R3 op readback", reg_rdata, 32'h3);

        // R5 stop
        bus(1, 0, 1, 32'h0);
        chk("R5 stop lines", 32'({diow_n, dior_n, cs1_n, cs0_n}), 32'hF);
        chk("R5 stop en", 32'(udma_en), 0);

        // R4 no read-back
        bus(1, 0, 1, 32'h0);
        bus(1, 0, 1, 32'h1);
        chk("R4 skipped readback en", 32'(udma_en), 0);
        chk("R4 skipped readback flag", 32'(seq_err), 1);
        // R4 direction mismatch
        bus(1, 0, 1, 32'h0);
        bus(0, 1, 1, 0);
        bus(1, 0, 1, 32'h3);
        chk("R4 dir mismatch en", 32'(udma_en), 0);
        bus(1, 0, 1, 32'h0);
        chk("R4 cleared by stop", 32'(seq_err), 0);

        // R7 priority ladder
        eng_req = 1; idle(1);
        chk("R7 active on req", 32'(xfer_cls), 1);
        ata_intrq = 1; idle(1);
        chk("R7 intr over active", 32'(xfer_cls), 2);
        eng_len_bad = 1; idle(1); eng_len_bad = 0; idle(1);
        chk("R7 error over intr", 32'(xfer_cls), 3);
        bus(0, 1, 2, 0);
        chk("R6 status sticky len", reg_rdata, 32'h0401_0000);
        ata_intrq = 0; eng_req = 0;

        // R6 clear and new pulse in the same cycle
        eng_out_short = 1;
        bus(1, 0, 1, 32'h0);
        eng_out_short = 0;
        bus(0, 1, 2, 0);
        chk("R6 pulse kept over clear", reg_rdata, 32'h0100_0000);
        bus(1, 0, 1, 32'h0);
        chk("R6 cleared", 32'(xfer_cls), 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int sel;
            sel = $urandom_range(0, 9);
            ata_intrq     = ($urandom_range(0, 3) == 0);
            eng_req       = ($urandom_range(0, 2) == 0);
            eng_busy      = ($urandom_range(0, 2) == 0);
            eng_err_irq   = ($urandom_range(0, 40) == 0);
            eng_out_short = ($urandom_range(0, 40) == 0);
            eng_in_short  = ($urandom_range(0, 40) == 0);
            eng_len_bad   = ($urandom_range(0, 40) == 0);
            case (sel)
                0, 1: bus(1, 0, 1, 32'($urandom_range(0, 3)));
                2, 3: bus(0, 1, 1, 0);
                4:    bus(1, 0, 1, 32'h0);
                5:    bus(1, 0, 0, $urandom);
                6:    bus(1, 0, 3, $urandom);
                7:    bus(0, 1, 2'($urandom_range(0, 3)), 0);
                default: bus(0, 0, 2'($urandom_range(0, 3)), $urandom);
            endcase
        end
        ata_intrq = 0; eng_req = 0; eng_busy = 0;
        eng_err_irq = 0; eng_out_short = 0; eng_in_short = 0; eng_len_bad = 0;
        idle(3);
        finish_run();
    end

endmodule